// File: doc/BRIEF.md
# Boost Converter Bypass Mode Controller

This block chooses, once per clock, whether a boost converter regulates or connects its output straight to its input through a bypass switch. Ideal digital comparator flags describe the analog state. One flag says the input sits above the target output plus a margin. A second, separate flag with its own threshold says the input has dropped back far enough to leave bypass, and the gap between the two thresholds gives the hysteresis. A third flag says the output is above the input. The PWM core supplies a switching-activity signal.

A mode pin picks the entry path. With the pin high, bypass is entered automatically when the input is high enough and the core has stopped switching for a full idle window. With the pin low, bypass is forced. In that case the regulator core is held off, and if the output is above the input it is first discharged down to the input level, so that no current flows back into the battery. When forced mode is released, the bypass switch opens and the core is restarted with a one-cycle start pulse. The outputs are gate-enable levels for three switches, a discharge enable, a core hold, a bypass status flag and the start pulse. All of them are decoded from a registered state, so a decision shows on the outputs one clock after the inputs are sampled.

Top module: `boost_bypass_ctrl`

## Requirements
- R1: One clock after `en` is sampled low, the block is in its off state: `byp_sw_en`, `ls_sw_en`, `hs_sw_en`, `dischg_en`, `in_bypass` and `core_start` are 0 and `core_hold` is 1. No other input changes this while `en` stays low.
- R2: In the off state, `en` sampled high moves the block to boost. In boost, `ls_sw_en`=1, `hs_sw_en`=1 and the other gate and discharge outputs and `core_hold` are 0. `core_start` is 1 for exactly the first boost cycle.
- R3: `auto_sel`=1 selects automatic bypass and `auto_sel`=0 selects forced bypass.
- R4: In boost with `auto_sel`=1, automatic bypass is entered on the edge after `sw_busy` has been sampled low on IDLE_CYC consecutive boost edges, provided `vin_hi_enter` is 1 on that edge. Any `sw_busy` high restarts the window. With `vin_hi_enter`=0, boost is kept.
- R5: In automatic bypass, `byp_sw_en`=1, `hs_sw_en`=1, `ls_sw_en`=0, `in_bypass`=1, and `core_hold`=0 and `dischg_en`=0.
- R6: In boost, `auto_sel`=0 with `vout_gt_vin`=0 leads to forced bypass. Forced bypass has the same switch outputs as R5, except that `core_hold`=1. While in forced bypass, `vout_gt_vin` is ignored.
- R7: In boost, `auto_sel`=0 with `vout_gt_vin`=1 leads to a discharge state. There, `dischg_en`=1, `core_hold`=1 and all three switch enables and `in_bypass` are 0. The discharge state lasts until `vout_gt_vin` is sampled 0, and then forced bypass follows.
- R8: In automatic bypass, dropping `vin_hi_enter` has no effect. Only `vin_lo_exit`=1 returns the block to boost, and it does so without a `core_start` pulse.
- R9: From forced bypass or from discharge, `auto_sel`=1 returns the block to boost with a one-cycle `core_start` pulse, and the bypass switch opens.
- R10: In automatic bypass, `auto_sel`=0 moves the block directly to forced bypass without discharging, whatever `vout_gt_vin` is.
- R11: In boost, a forced request takes precedence over an automatic entry whose conditions are met on the same edge.
- R12: `byp_sw_en` and `ls_sw_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| auto_sel | input | 1 | 1 = automatic bypass, 0 = forced bypass |
| vin_hi_enter | input | 1 | Input above target plus entry margin |
| vin_lo_exit | input | 1 | Input below the bypass exit threshold |
| vout_gt_vin | input | 1 | Output voltage above input voltage |
| sw_busy | input | 1 | PWM core switched this cycle |
| byp_sw_en | output | 1 | Bypass switch gate enable |
| ls_sw_en | output | 1 | Low-side switch gate enable |
| hs_sw_en | output | 1 | High-side switch gate enable |
| dischg_en | output | 1 | Output discharge enable |
| core_hold | output | 1 | Holds the boost core disabled |
| in_bypass | output | 1 | Bypass status flag |
| core_start | output | 1 | One-cycle boost restart pulse |

## Verification
The hardest case to reach is an automatic entry that is decided by the idle window alone. To get there, the stimulus lets part of the window run out, restarts it with one switching pulse, and then counts a full window edge by edge. It checks that boost still holds on the last edge of the window and that bypass appears on the next edge. It then lets the window run out with the entry flag low and raises the flag afterwards, so that the flag is the only thing that decides the moment of entry. Priority is tested by asking for forced bypass on the exact edge where the automatic conditions mature.

// File: rtl/byp_ctrl_pkg.sv
package byp_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_BOOST      = 3'd1,
        ST_AUTO_BYP   = 3'd2,
        ST_DISCHG     = 3'd3,
        ST_FORCED_BYP = 3'd4
    } byp_state_e;

    typedef struct packed {
        logic byp_sw;
        logic ls_sw;
        logic hs_sw;
        logic dischg;
        logic core_hold;
        logic bypass;
    } gate_ctrl_t;

    // Output levels held in each state.
    function automatic gate_ctrl_t state_gates(input byp_state_e st);
        gate_ctrl_t g;
        g = '0;
        unique case (st)
            ST_OFF: begin
                g.core_hold = 1'b1;
            end
            ST_BOOST: begin
                g.ls_sw = 1'b1;
                g.hs_sw = 1'b1;
            end
            ST_AUTO_BYP: begin
                g.byp_sw = 1'b1;
                g.hs_sw  = 1'b1;
                g.bypass = 1'b1;
            end
            ST_DISCHG: begin
                g.dischg    = 1'b1;
                g.core_hold = 1'b1;
            end
            ST_FORCED_BYP: begin
                g.byp_sw    = 1'b1;
                g.hs_sw     = 1'b1;
                g.bypass    = 1'b1;
                g.core_hold = 1'b1;
            end
            default: g.core_hold = 1'b1;
        endcase
        return g;
    endfunction

    // States that leave the core halted, so entering boost needs a restart.
    function automatic logic needs_restart(input byp_state_e st);
        return (st == ST_OFF) || (st == ST_DISCHG) || (st == ST_FORCED_BYP);
    endfunction

endpackage

// File: rtl/byp_idle_timer.sv
module byp_idle_timer #(
    parameter int IDLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic window_done
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != LIMIT) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign window_done = (quiet_cnt == LIMIT);

    // R4: a completed window needs a quiet edge just before it.
    p_window_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        window_done |-> !$past(restart));

endmodule

// File: rtl/byp_mode_fsm.sv
module byp_mode_fsm
    import byp_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       auto_sel,
    input  logic       vin_hi_enter,
    input  logic       vin_lo_exit,
    input  logic       vout_gt_vin,
    input  logic       idle_done,
    output byp_state_e state,
    output logic       start_pulse
);
    byp_state_e nxt;

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: nxt = ST_BOOST;
                ST_BOOST: begin
                    if (!auto_sel)
                        nxt = vout_gt_vin ? ST_DISCHG : ST_FORCED_BYP;
                    else if (vin_hi_enter && idle_done)
                        nxt = ST_AUTO_BYP;
                end
                ST_AUTO_BYP: begin
                    if (!auto_sel)        nxt = ST_FORCED_BYP;
                    else if (vin_lo_exit) nxt = ST_BOOST;
                end
                ST_DISCHG: begin
                    if (auto_sel)          nxt = ST_BOOST;
                    else if (!vout_gt_vin) nxt = ST_FORCED_BYP;
                end
                ST_FORCED_BYP: begin
                    if (auto_sel) nxt = ST_BOOST;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_OFF;
            start_pulse <= 1'b0;
        end else begin
            state       <= nxt;
            start_pulse <= (nxt == ST_BOOST) && needs_restart(state);
        end
    end

    // R9: the start pulse is one cycle long.
    p_start_single_r9: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R4: automatic entry only from boost after a full idle window.
    p_auto_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AUTO_BYP && $past(state) == ST_BOOST) |->
            $past(idle_done) && $past(vin_hi_enter));

    // R7: forced bypass after discharge only once the output has come down.
    p_dischg_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FORCED_BYP && $past(state) == ST_DISCHG) |->
            !$past(vout_gt_vin));

endmodule

// File: rtl/byp_gate_decode.sv
module byp_gate_decode
    import byp_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  byp_state_e state,
    output gate_ctrl_t gates
);
    assign gates = state_gates(state);

    // R12: the bypass and low-side switches are never on together.
    p_no_shoot_r12: assert property (@(posedge clk) disable iff (rst)
        !(gates.byp_sw && gates.ls_sw));

    // R7: no switch is on while the output is being discharged.
    p_dischg_isolated_r7: assert property (@(posedge clk) disable iff (rst)
        gates.dischg |-> !(gates.byp_sw || gates.ls_sw || gates.hs_sw));

endmodule

// File: rtl/boost_bypass_ctrl.sv
module boost_bypass_ctrl
    import byp_ctrl_pkg::*;
#(
    parameter int IDLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic auto_sel,
    input  logic vin_hi_enter,
    input  logic vin_lo_exit,
    input  logic vout_gt_vin,
    input  logic sw_busy,
    output logic byp_sw_en,
    output logic ls_sw_en,
    output logic hs_sw_en,
    output logic dischg_en,
    output logic core_hold,
    output logic in_bypass,
    output logic core_start
);
    byp_state_e state;
    gate_ctrl_t gates;
    logic       idle_done;
    logic       idle_restart;

    assign idle_restart = sw_busy || (state != ST_BOOST);

    byp_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk         (clk),
        .rst         (rst),
        .restart     (idle_restart),
        .window_done (idle_done)
    );

    byp_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .auto_sel     (auto_sel),
        .vin_hi_enter (vin_hi_enter),
        .vin_lo_exit  (vin_lo_exit),
        .vout_gt_vin  (vout_gt_vin),
        .idle_done    (idle_done),
        .state        (state),
        .start_pulse  (core_start)
    );

    byp_gate_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .gates (gates)
    );

    assign byp_sw_en = gates.byp_sw;
    assign ls_sw_en  = gates.ls_sw;
    assign hs_sw_en  = gates.hs_sw;
    assign dischg_en = gates.dischg;
    assign core_hold = gates.core_hold;
    assign in_bypass = gates.bypass;

    // R1: a low enable turns every switch off on the next cycle.
    p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !(byp_sw_en || ls_sw_en || hs_sw_en || dischg_en));

endmodule

// File: tb/boost_bypass_ctrl_tb_top.sv
module boost_bypass_ctrl_tb_top;
    localparam int IDLE = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, auto_sel = 1'b1, vin_hi_enter = 1'b0, vin_lo_exit = 1'b0;
    logic vout_gt_vin = 1'b0, sw_busy = 1'b0;
    logic byp_sw_en, ls_sw_en, hs_sw_en, dischg_en, core_hold, in_bypass, core_start;

    always #2.5 clk = ~clk;

    boost_bypass_ctrl #(.IDLE_CYC(IDLE)) dut_i (
        .clk(clk), .rst(rst), .en(en), .auto_sel(auto_sel),
        .vin_hi_enter(vin_hi_enter), .vin_lo_exit(vin_lo_exit),
        .vout_gt_vin(vout_gt_vin), .sw_busy(sw_busy),
        .byp_sw_en(byp_sw_en), .ls_sw_en(ls_sw_en), .hs_sw_en(hs_sw_en),
        .dischg_en(dischg_en), .core_hold(core_hold), .in_bypass(in_bypass),
        .core_start(core_start)
    );

    // Expected vector: {bypass, low, high, discharge, hold, flag, start}
    localparam logic [6:0] E_OFF    = 7'b0000100;
    localparam logic [6:0] E_BOOST  = 7'b0110000;
    localparam logic [6:0] E_AUTO   = 7'b1010010;
    localparam logic [6:0] E_DISCHG = 7'b0001100;
    localparam logic [6:0] E_FORCED = 7'b1010110;
    localparam logic [6:0] START    = 7'b0000001;

    logic [6:0] exp_q[$];
    string      tag_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Monitor: pops one expectation per cycle, away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [6:0] e;
            logic [6:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {byp_sw_en, ls_sw_en, hs_sw_en, dischg_en, core_hold, in_bypass, core_start};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: outputs=%b expected=%b", t, a, e);
            end
            checks++;
            if (byp_sw_en && ls_sw_en) begin
                fails++;
                $display("FAIL R12: bypass=%b low=%b expected not both 1", byp_sw_en, ls_sw_en);
            end
        end
    end

    // Driver: one clock edge, then the expected result is queued.
    task automatic step(input logic [6:0] e, input string t);
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    task automatic quiet_window(input int n, input string t);
        for (int i = 0; i < n; i++) step(E_BOOST, t);
    endtask

    task automatic finish_run();
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(E_OFF, "R1 reset/off");
        auto_sel = 1'b0; vout_gt_vin = 1'b1;
        step(E_OFF, "R1 inputs ignored while disabled");
        auto_sel = 1'b1; vout_gt_vin = 1'b0;

        en = 1'b1; sw_busy = 1'b1;
        step(E_BOOST | START, "R2 start pulse");
        step(E_BOOST, "R2 pulse one cycle");

        // R4: window restarted by switching activity.
        sw_busy = 1'b0; vin_hi_enter = 1'b1;
        quiet_window(IDLE / 2, "R4 partial window");
        sw_busy = 1'b1;
        step(E_BOOST, "R4 switching");
        sw_busy = 1'b0;
        quiet_window(IDLE, "R4 restarted window");
        vin_hi_enter = 1'b0;
        step(E_BOOST, "R4 no entry without enter flag");
        step(E_BOOST, "R4 no entry without enter flag");
        vin_hi_enter = 1'b1;
        step(E_AUTO, "R5 auto bypass entered");

        vin_hi_enter = 1'b0;
        step(E_AUTO, "R8 hysteresis hold");
        vin_lo_exit = 1'b1;
        step(E_BOOST, "R8 exit without start");
        vin_lo_exit = 1'b0;

        // Forced bypass from boost.
        auto_sel = 1'b0;
        step(E_FORCED, "R6 R3 forced bypass");
        vout_gt_vin = 1'b1;
        step(E_FORCED, "R6 vout flag ignored");
        auto_sel = 1'b1; vout_gt_vin = 1'b0;
        step(E_BOOST | START, "R9 release restarts");
        step(E_BOOST, "R9 pulse one cycle");

        // Discharge path.
        auto_sel = 1'b0; vout_gt_vin = 1'b1;
        step(E_DISCHG, "R7 discharge");
        step(E_DISCHG, "R7 discharge held");
        vout_gt_vin = 1'b0;
        step(E_FORCED, "R7 forced after discharge");

        // Auto bypass -> forced without discharge.
        auto_sel = 1'b1;
        step(E_BOOST | START, "R9 release");
        vin_hi_enter = 1'b1;
        quiet_window(IDLE, "R4 window");
        step(E_AUTO, "R4 entry at window end");
        auto_sel = 1'b0; vout_gt_vin = 1'b1;
        step(E_FORCED, "R10 auto to forced direct");

        // Priority on the maturing edge.
        auto_sel = 1'b1; vout_gt_vin = 1'b0;
        step(E_BOOST | START, "R9 release");
        quiet_window(IDLE, "R11 window");
        auto_sel = 1'b0;
        step(E_FORCED, "R11 forced wins");

        // Release from discharge.
        auto_sel = 1'b1;
        step(E_BOOST | START, "R9 release");
        auto_sel = 1'b0; vout_gt_vin = 1'b1;
        step(E_DISCHG, "R7 discharge");
        auto_sel = 1'b1;
        step(E_BOOST | START, "R9 release from discharge");

        // Disable from forced bypass.
        auto_sel = 1'b0; vout_gt_vin = 1'b0;
        step(E_FORCED, "R6 forced");
        en = 1'b0;
        step(E_OFF, "R1 disable");
        auto_sel = 1'b1; vin_hi_enter = 1'b1;
        step(E_OFF, "R1 stays off");
        en = 1'b1;
        step(E_BOOST | START, "R2 re-enable");
        step(E_BOOST, "R2 boost");

        finish_run();
    end
endmodule